// File: doc/BRIEF.md
# UART Channel FIFO Controller with Trigger Thresholds

This block holds the receive and transmit data queues of one serial channel. Each queue is 64 bytes deep. A write-only control byte governs both queues. The byte turns queued operation on or off, empties either queue through a one-shot clear bit, picks one of two DMA signalling modes, and selects a fill threshold for each direction. The receive threshold counts stored characters, and the transmit threshold counts free slots. The block compares the live levels against these thresholds and raises a receive-ready flag and a transmit-ready flag.

When queued operation is off, each direction acts as a one-byte holding register. A clear empties only the queue's storage and pointers; the serial shift registers outside the block are not affected. The transmit threshold field is an enhanced function, so a write to it has effect only while an external enable input is high.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, `fifo_en` and `dma_mode` are 0, both levels are 0, `rx_ready` is 0, `tx_ready` is 1, and both overflow pulses are 0. Both threshold codes start at 00.
- R2: A write loads `fifo_en` from bit 0, `dma_mode` from bit 3 and the receive threshold code from bits 7:6. Each output reflects the new value from the cycle after the write.
- R3: A push to a full queue is dropped and the level stays unchanged. The matching overflow output is 1 for exactly the one cycle after that push. Full means 64 entries when enabled and 1 entry when disabled.
- R4: With queues enabled, `rx_ready` is 1 exactly when `rx_level` ≥ the receive threshold. Receive code 00 gives 8, 01 gives 16, 10 gives 56 and 11 gives 60.
- R5: With queues enabled, `tx_ready` is 1 exactly when 64 − `tx_level` ≥ the transmit threshold. Transmit code (bits 5:4) 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 56.
- R6: Bits 5:4 of a write update the transmit code only when `enh_en` is 1. Otherwise the previous code is kept.
- R7: A write with bit 1 set makes `rx_level` 0 in the following cycle. A receive push in the same cycle is dropped. The clear acts once, so a later write with bit 1 at 0 leaves the queue alone.
- R8: A write with bit 2 set makes `tx_level` 0 in the following cycle. A transmit push in the same cycle is dropped. The receive queue is unaffected.
- R9: A pop from an empty queue leaves the level at 0 and keeps the data output at the last value read.
- R10: With queues disabled, `rx_ready` equals (`rx_level` = 1) and `tx_ready` equals (`tx_level` = 0).
- R11: Bytes come out in push order. The data output holds the popped byte from the cycle after the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| enh_en | input | 1 | Enhanced-function enable; gates the transmit threshold field |
| tx_push | input | 1 | Store `tx_din` into the transmit queue |
| tx_din | input | 8 | Transmit byte in |
| tx_pop | input | 1 | Take one byte from the transmit queue |
| tx_dout | output | 8 | Last byte taken from the transmit queue |
| rx_push | input | 1 | Store `rx_din` into the receive queue |
| rx_din | input | 8 | Receive byte in |
| rx_pop | input | 1 | Take one byte from the receive queue |
| rx_dout | output | 8 | Last byte taken from the receive queue |
| fifo_en | output | 1 | Queued operation enabled |
| dma_mode | output | 1 | Selected DMA signalling mode |
| rx_level | output | 7 | Receive queue fill level |
| tx_level | output | 7 | Transmit queue fill level |
| rx_ready | output | 1 | Receive threshold reached |
| tx_ready | output | 1 | Transmit free-space threshold reached |
| rx_ovf | output | 1 | One-cycle pulse on a dropped receive push |
| tx_ovf | output | 1 | One-cycle pulse on a dropped transmit push |

## Verification
The bench builds the block with its default parameters: a depth of 64 and 8-bit data. These values are small enough that every level from empty to full can be visited one push at a time. For each of the four codes in each direction, the ready flag is compared at every level against a threshold the bench computes itself. The sweeps also reach the overflow point, the gated transmit-code write, and clears that land in the same cycle as a push.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // Receive threshold in stored characters for a 2-bit code.
  function automatic int rx_thresh(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 56;
      default: return 60;
    endcase
  endfunction

  // Transmit threshold in free slots for a 2-bit code.
  function automatic int tx_thresh(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 56;
    endcase
  endfunction

endpackage

// File: rtl/fifo_ctl_reg.sv
module fifo_ctl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       enh_en,
  output logic       fifo_en,
  output logic       dma_mode,
  output logic [1:0] rx_trig,
  output logic [1:0] tx_trig,
  output logic       rx_clr,
  output logic       tx_clr
);
  // Clear bits are never stored: each write strobe yields one clear.
  assign rx_clr = we & wdata[1];
  assign tx_clr = we & wdata[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      dma_mode <= 1'b0;
      rx_trig  <= 2'b00;
      tx_trig  <= 2'b00;
    end else if (we) begin
      fifo_en  <= wdata[0];
      dma_mode <= wdata[3];
      rx_trig  <= wdata[7:6];
      if (enh_en) tx_trig <= wdata[5:4];
    end
  end
endmodule

// File: rtl/chan_fifo.sv
module chan_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cap_one,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             ovf
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             full, push_ok, pop_ok, push_drop;

  assign full      = cap_one ? (count != '0) : (count == CW'(DEPTH));
  assign push_ok   = push & ~clr & ~full;
  assign push_drop = push & ~clr & full;
  assign pop_ok    = pop & ~clr & (count != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      dout   <= '0;
      ovf    <= 1'b0;
    end else begin
      ovf <= push_drop;
      if (clr) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
      end else begin
        if (push_ok) wr_ptr <= wr_ptr + AW'(1);
        if (pop_ok) begin
          rd_ptr <= rd_ptr + AW'(1);
          dout   <= mem[rd_ptr];
        end
        case ({push_ok, pop_ok})
          2'b10:   count <= count + CW'(1);
          2'b01:   count <= count - CW'(1);
          default: count <= count;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  input  logic             enh_en,
  input  logic             tx_push,
  input  logic [WIDTH-1:0] tx_din,
  input  logic             tx_pop,
  output logic [WIDTH-1:0] tx_dout,
  input  logic             rx_push,
  input  logic [WIDTH-1:0] rx_din,
  input  logic             rx_pop,
  output logic [WIDTH-1:0] rx_dout,
  output logic             fifo_en,
  output logic             dma_mode,
  output logic [CW-1:0]    rx_level,
  output logic [CW-1:0]    tx_level,
  output logic             rx_ready,
  output logic             tx_ready,
  output logic             rx_ovf,
  output logic             tx_ovf
);
  import uart_fifo_pkg::*;

  logic [1:0] rx_trig_q, tx_trig_q;
  logic       rx_clr, tx_clr;
  int         rx_thr, tx_thr, tx_free;

  fifo_ctl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .enh_en(enh_en),
    .fifo_en(fifo_en), .dma_mode(dma_mode), .rx_trig(rx_trig_q),
    .tx_trig(tx_trig_q), .rx_clr(rx_clr), .tx_clr(tx_clr)
  );

  chan_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .cap_one(~fifo_en),
    .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_dout),
    .count(rx_level), .ovf(rx_ovf)
  );

  chan_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .cap_one(~fifo_en),
    .push(tx_push), .din(tx_din), .pop(tx_pop), .dout(tx_dout),
    .count(tx_level), .ovf(tx_ovf)
  );

  assign rx_thr  = rx_thresh(rx_trig_q);
  assign tx_thr  = tx_thresh(tx_trig_q);
  assign tx_free = DEPTH - int'(tx_level);

  always_comb begin
    if (fifo_en) begin
      rx_ready = int'(rx_level) >= rx_thr;
      tx_ready = tx_free >= tx_thr;
    end else begin
      rx_ready = (rx_level != '0);
      tx_ready = (tx_level == '0);
    end
  end
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [7:0]       cfg_wdata,
  input logic             enh_en,
  input logic             rx_push,
  input logic             rx_pop,
  input logic             fifo_en,
  input logic [CW-1:0]    rx_level,
  input logic [CW-1:0]    tx_level,
  input logic [WIDTH-1:0] rx_dout,
  input logic             rx_ovf,
  input logic [1:0]       tx_trig_q
);
  // R3: levels never pass the depth
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_level) <= DEPTH) && (int'(tx_level) <= DEPTH));

  // R3: an overflow pulse needs a push into a non-empty queue one cycle earlier
  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |-> ($past(rx_push) && ($past(rx_level) != '0)));

  // R6: a gated write keeps the transmit code
  assert_tx_trig_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !enh_en) |=> $stable(tx_trig_q));

  // R7: receive clear empties the queue
  assert_rx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[1]) |=> (rx_level == '0));

  // R8: transmit clear empties the queue
  assert_tx_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[2]) |=> (tx_level == '0));

  // R9: empty pop keeps data out
  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_level == '0) |=> $stable(rx_dout));

  // R10: disabled queue holds at most one byte
  assert_one_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rx_level <= CW'(1) && !(cfg_we && cfg_wdata[0]))
      |=> (rx_level <= CW'(1)));
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .enh_en(enh_en), .rx_push(rx_push), .rx_pop(rx_pop), .fifo_en(fifo_en),
  .rx_level(rx_level), .tx_level(tx_level), .rx_dout(rx_dout),
  .rx_ovf(rx_ovf), .tx_trig_q(tx_trig_q)
);

// File: tb/uart_fifo_ctl_tb.sv
module uart_fifo_ctl_tb_top;
  localparam int D = 64;

  logic       clk = 0, rst_n = 0;
  logic       cfg_we = 0, enh_en = 0;
  logic [7:0] cfg_wdata = 0;
  logic       tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0] tx_din = 0, rx_din = 0, tx_dout, rx_dout;
  logic       fifo_en, dma_mode, rx_ready, tx_ready, rx_ovf, tx_ovf;
  logic [6:0] rx_level, tx_level;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_fifo_ctl dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected thresholds, computed as powers of two with exceptions.
  function automatic int exp_rx_thr(input int c);
    return (c == 3) ? 60 : (c == 2) ? 56 : (8 << c);
  endfunction
  function automatic int exp_tx_thr(input int c);
    return (c == 3) ? 56 : (8 << c);
  endfunction

  function automatic logic [7:0] cb(input bit en, input bit rc, input bit tc,
                                    input bit dm, input int tt, input int rt);
    return {rt[1:0], tt[1:0], dm, tc, rc, en};
  endfunction

  task automatic wr(input logic [7:0] d, input bit enh);
    @(negedge clk); cfg_we = 1; cfg_wdata = d; enh_en = enh;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic push_rx(input logic [7:0] d);
    @(negedge clk); rx_push = 1; rx_din = d;
    @(negedge clk); rx_push = 0;
  endtask
  task automatic push_tx(input logic [7:0] d);
    @(negedge clk); tx_push = 1; tx_din = d;
    @(negedge clk); tx_push = 0;
  endtask
  task automatic pop_rx();
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 fifo_en", fifo_en, 0);
    check("R1 dma_mode", dma_mode, 0);
    check("R1 rx_level", rx_level, 0);
    check("R1 tx_level", tx_level, 0);
    check("R1 rx_ready", rx_ready, 0);
    check("R1 tx_ready", tx_ready, 1);
    check("R1 ovf", rx_ovf | tx_ovf, 0);

    // R10 disabled single-slot behaviour
    push_rx(8'h11);
    check("R10 rx_level", rx_level, 1);
    check("R10 rx_ready", rx_ready, 1);
    push_rx(8'h22);
    check("R3 disabled ovf", rx_ovf, 1);
    check("R3 disabled level", rx_level, 1);
    @(negedge clk);
    check("R3 ovf one cycle", rx_ovf, 0);
    push_tx(8'h33);
    check("R10 tx_ready", tx_ready, 0);
    pop_rx();
    check("R11 disabled pop", rx_dout, 8'h11);

    // R2 register fields
    wr(cb(1, 1, 1, 1, 0, 2), 1);
    check("R2 fifo_en", fifo_en, 1);
    check("R2 dma_mode", dma_mode, 1);
    check("R8 tx cleared", tx_level, 0);
    wr(cb(1, 0, 0, 0, 0, 0), 1);
    check("R2 dma back", dma_mode, 0);

    // R4 receive thresholds across all levels
    for (int c = 0; c < 4; c++) begin
      wr(cb(1, 1, 0, 0, 0, c), 1);
      check("R4 cleared", rx_level, 0);
      for (int k = 1; k <= D; k++) begin
        push_rx(k[7:0]);
        check("R4 rx_ready", rx_ready, (k >= exp_rx_thr(c)) ? 1 : 0);
      end
      push_rx(8'hEE);
      check("R3 ovf full", rx_ovf, 1);
      check("R3 level full", rx_level, D);
    end

    // R5 transmit thresholds across all levels
    for (int c = 0; c < 4; c++) begin
      wr(cb(1, 0, 1, 0, c, 0), 1);
      check("R5 cleared", tx_level, 0);
      check("R5 tx_ready empty", tx_ready, 1);
      for (int k = 1; k <= D; k++) begin
        push_tx(k[7:0]);
        check("R5 tx_ready", tx_ready, ((D - k) >= exp_tx_thr(c)) ? 1 : 0);
      end
      push_tx(8'hEE);
      check("R3 tx ovf", tx_ovf, 1);
    end

    // R6 gated transmit-code write: code stays 11 (56) despite write of 00
    wr(cb(1, 0, 1, 0, 0, 0), 0);
    for (int k = 0; k < 8; k++) push_tx(8'h0);
    check("R6 free 56 ready", tx_ready, 1);
    push_tx(8'h0);
    check("R6 free 55 not ready", tx_ready, 0);
    wr(cb(1, 0, 1, 0, 0, 0), 1);
    for (int k = 0; k < 56; k++) push_tx(8'h0);
    check("R6 code now 00 free 8", tx_ready, 1);

    // R11 ordering and R9 empty pop
    wr(cb(1, 1, 1, 0, 0, 0), 1);
    for (int k = 0; k < 5; k++) push_rx(8'hA0 + k[7:0]);
    for (int k = 0; k < 5; k++) begin
      pop_rx();
      check("R11 order", rx_dout, 8'hA0 + k);
    end
    pop_rx();
    check("R9 empty dout", rx_dout, 8'hA4);
    check("R9 empty level", rx_level, 0);

    // R7/R8 clears during push traffic
    for (int k = 0; k < 10; k++) push_rx(8'h5);
    for (int k = 0; k < 3; k++) push_tx(8'h6);
    @(negedge clk);
    rx_push = 1; tx_push = 1; cfg_we = 1; cfg_wdata = cb(1, 1, 0, 0, 0, 0);
    @(negedge clk);
    cfg_we = 0;
    check("R7 rx cleared under push", rx_level, 0);
    check("R8 tx untouched", tx_level, 4);
    @(negedge clk);
    check("R7 push after clear", rx_level, 1);
    cfg_we = 1; cfg_wdata = cb(1, 0, 1, 0, 0, 0);
    @(negedge clk);
    cfg_we = 0; rx_push = 0; tx_push = 0;
    check("R8 tx cleared under push", tx_level, 0);
    check("R7 no repeat clear", rx_level, 2);
    wr(cb(1, 0, 0, 0, 0, 0), 1);
    check("R7 self-cleared", rx_level, 2);

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <%0d", cyc, 50000);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule